// File: doc/BRIEF.md
# Outbound Address Translator

This block maps local bus addresses to remote target addresses through a small set of outbound regions. Each region has a base, an inclusive limit, a target and a transaction-type code. Software reaches the region registers indirectly. It first writes a selector register that names a direction and a region index. It then programs the selected region through a shared group of window registers. Reads through the window return the fields of the currently selected region.

On the translation side, a request carries a 64-bit local address. The block compares it against every enabled region. One clock later it returns a response. On a hit, the response holds the winning region, its type code and the translated address. For the two configuration type codes, the response also holds the bus, device and function numbers taken from the region's target register. On a miss, the local address passes through untranslated. The translation always uses the register values current on the request cycle, so fields may be programmed in any order around the enable bit.

Top module: `outbound_atu`

## Requirements
- R1: After reset every register reads zero, no region is enabled, `rsp_valid` is low, and a request for address zero misses.
- R2: The selector register at offset 0x900 stores the direction in bit 31 (1 = inbound, 0 = outbound) and the region index in its low bits (bit 0 for two regions). It reads back only those bits; all other bits read zero.
- R3: The window registers at 0x90C (base low), 0x910 (base high), 0x914 (limit), 0x918 (target low) and 0x91C (target high) act on the region chosen by the selector. The values of a region that is not selected are kept, and read back unchanged once that region is selected again.
- R4: Control register 0x904 holds the type code in bits 4:0 (memory 0, I/O 2, configuration type 0 = 4, configuration type 1 = 5). Control register 0x908 holds the enable in bit 31 and a stored-only bar-mode flag in bit 30. Other bits of both registers read zero.
- R5: While the selector names the inbound direction, window writes are dropped and window reads return zero. An access at any offset other than 0x900 to 0x91C on a 4-byte boundary is ignored and reads zero.
- R6: A region hits only when it is enabled, the upper 32 address bits equal its base high, and base low ≤ address[31:0] ≤ limit. Both ends of this range are included.
- R7: On a hit, `rsp_addr` = {target high, target low} + (address − {base high, base low}), and `rsp_type` is the region's type code.
- R8: When several regions hit, the lowest-numbered region wins.
- R9: On a miss, `rsp_hit` is 0, `rsp_addr` equals the request address, and `rsp_type` and `rsp_region` are 0.
- R10: When the winning type code is 4 or 5, `rsp_bus`, `rsp_dev` and `rsp_func` are target-low bits 31:24, 23:19 and 18:16. In every other case these outputs are zero.
- R11: Every request cycle gives exactly one response cycle on the next clock. Without a request, `rsp_valid` and `rsp_hit` are low.
- R12: A change to the base or limit of a region that is already enabled applies to the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| req_valid | input | 1 | Translation request present |
| req_addr | input | 64 | Local address to translate |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_hit | output | 1 | A region matched |
| rsp_region | output | IDX_W (1) | Winning region index |
| rsp_type | output | 5 | Type code of the winning region |
| rsp_addr | output | 64 | Translated or passed-through address |
| rsp_bus | output | 8 | Bus number for configuration types |
| rsp_dev | output | 5 | Device number for configuration types |
| rsp_func | output | 3 | Function number for configuration types |

## Verification
The checker watches several properties on every cycle. It checks the one-cycle request-to-response timing and that the lower-numbered region wins whenever it matches. It also checks that a miss passes the address through, that disabled regions never hit, and that bus, device and function stay zero for non-configuration types. It further checks that window writes under an inbound selection leave all region state unchanged. The bench scenarios cover what needs a known programmed state. That includes exact translated values at both inclusive edges of a window and read-back of a region's fields after the selector moves away and back. It also includes the bit masking of the selector and control registers, and translation after an enabled region is moved.

// File: rtl/atu_pkg.sv
package atu_pkg;

  // Register offsets; software decodes these, so they are fixed.
  localparam int unsigned OFF_VIEW  = 'h900;
  localparam int unsigned OFF_CTRL1 = 'h904;
  localparam int unsigned OFF_CTRL2 = 'h908;
  localparam int unsigned OFF_LBASE = 'h90C;
  localparam int unsigned OFF_UBASE = 'h910;
  localparam int unsigned OFF_LIMIT = 'h914;
  localparam int unsigned OFF_LTGT  = 'h918;
  localparam int unsigned OFF_UTGT  = 'h91C;

  localparam int unsigned KIND_W = 5;
  localparam logic [KIND_W-1:0] KIND_MEM  = 5'd0;
  localparam logic [KIND_W-1:0] KIND_IO   = 5'd2;
  localparam logic [KIND_W-1:0] KIND_CFG0 = 5'd4;
  localparam logic [KIND_W-1:0] KIND_CFG1 = 5'd5;

  // Bit positions inside control register 2.
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned BAR_BIT = 30;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_CTRL1, FLD_CTRL2, FLD_LBASE,
    FLD_UBASE, FLD_LIMIT, FLD_LTGT, FLD_UTGT
  } field_e;

  typedef struct packed {
    logic [31:0]       lbase;
    logic [31:0]       ubase;
    logic [31:0]       limit;
    logic [31:0]       ltgt;
    logic [31:0]       utgt;
    logic [KIND_W-1:0] kind;
    logic              en;
    logic              bar;
  } region_t;

  // Inclusive window test; the limit shares the upper base word.
  function automatic logic in_window(region_t r, logic [63:0] a);
    return r.en && (a[63:32] == r.ubase) &&
           (a[31:0] >= r.lbase) && (a[31:0] <= r.limit);
  endfunction

  // Remap: target plus the offset of the address inside the window.
  function automatic logic [63:0] remap(region_t r, logic [63:0] a);
    logic [63:0] off;
    off = a - {r.ubase, r.lbase};
    return {r.utgt, r.ltgt} + off;
  endfunction

  function automatic logic is_cfg(logic [KIND_W-1:0] k);
    return (k == KIND_CFG0) || (k == KIND_CFG1);
  endfunction

endpackage

// File: rtl/atu_regfile.sv
module atu_regfile
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int ADDR_W      = 12,
  parameter int IDX_W       = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [31:0]                   wdata,
  output logic [31:0]                   rdata,
  output region_t [NUM_REGIONS-1:0]     regs,
  output logic                          vp_inbound,
  output logic                          win_access
);

  logic             vp_in_q;
  logic [IDX_W-1:0] vp_idx_q;
  region_t          regs_q [NUM_REGIONS];
  field_e           fsel;
  logic             view_sel;
  region_t          cur;

  assign view_sel = (addr == ADDR_W'(OFF_VIEW));

  always_comb begin
    case (addr)
      ADDR_W'(OFF_CTRL1): fsel = FLD_CTRL1;
      ADDR_W'(OFF_CTRL2): fsel = FLD_CTRL2;
      ADDR_W'(OFF_LBASE): fsel = FLD_LBASE;
      ADDR_W'(OFF_UBASE): fsel = FLD_UBASE;
      ADDR_W'(OFF_LIMIT): fsel = FLD_LIMIT;
      ADDR_W'(OFF_LTGT):  fsel = FLD_LTGT;
      ADDR_W'(OFF_UTGT):  fsel = FLD_UTGT;
      default:            fsel = FLD_NONE;
    endcase
  end

  assign win_access = (fsel != FLD_NONE);
  assign vp_inbound = vp_in_q;

  // Selector register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp_in_q  <= 1'b0;
      vp_idx_q <= '0;
    end else if (we && view_sel) begin
      vp_in_q  <= wdata[31];
      vp_idx_q <= wdata[IDX_W-1:0];
    end
  end

  // Region storage, written only through an outbound selection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGIONS; i++) regs_q[i] <= '0;
    end else if (we && win_access && !vp_in_q) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (vp_idx_q == IDX_W'(i)) begin
          case (fsel)
            FLD_CTRL1: regs_q[i].kind <= wdata[KIND_W-1:0];
            FLD_CTRL2: begin
              regs_q[i].en  <= wdata[EN_BIT];
              regs_q[i].bar <= wdata[BAR_BIT];
            end
            FLD_LBASE: regs_q[i].lbase <= wdata;
            FLD_UBASE: regs_q[i].ubase <= wdata;
            FLD_LIMIT: regs_q[i].limit <= wdata;
            FLD_LTGT:  regs_q[i].ltgt  <= wdata;
            FLD_UTGT:  regs_q[i].utgt  <= wdata;
            default: ;
          endcase
        end
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_out
      assign regs[g] = regs_q[g];
    end
  endgenerate

  // Selected region for window reads
  always_comb begin
    cur = '0;
    for (int i = 0; i < NUM_REGIONS; i++)
      if (vp_idx_q == IDX_W'(i)) cur = regs_q[i];
  end

  always_comb begin
    rdata = '0;
    if (view_sel) begin
      rdata[31]        = vp_in_q;
      rdata[IDX_W-1:0] = vp_idx_q;
    end else if (win_access && !vp_in_q) begin
      case (fsel)
        FLD_CTRL1: rdata[KIND_W-1:0] = cur.kind;
        FLD_CTRL2: begin
          rdata[EN_BIT]  = cur.en;
          rdata[BAR_BIT] = cur.bar;
        end
        FLD_LBASE: rdata = cur.lbase;
        FLD_UBASE: rdata = cur.ubase;
        FLD_LIMIT: rdata = cur.limit;
        FLD_LTGT:  rdata = cur.ltgt;
        FLD_UTGT:  rdata = cur.utgt;
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/atu_match.sv
module atu_match
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int IDX_W       = 1
) (
  input  region_t [NUM_REGIONS-1:0] regs,
  input  logic [63:0]               req_addr,
  output logic [NUM_REGIONS-1:0]    hit_vec,
  output logic                      any_hit,
  output logic [IDX_W-1:0]          win_idx,
  output logic [63:0]               win_addr,
  output logic [KIND_W-1:0]         win_kind,
  output logic [15:0]               win_bdf
);

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_cmp
      assign hit_vec[g] = in_window(regs[g], req_addr);
    end
  endgenerate

  assign any_hit = |hit_vec;

  // Scan from the top down so the lowest matching index is kept.
  always_comb begin
    win_idx  = '0;
    win_addr = req_addr;
    win_kind = KIND_MEM;
    win_bdf  = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        win_idx  = IDX_W'(i);
        win_addr = remap(regs[i], req_addr);
        win_kind = regs[i].kind;
        win_bdf  = regs[i].ltgt[31:16];
      end
    end
  end

endmodule

// File: rtl/atu_rsp_stage.sv
module atu_rsp_stage
  import atu_pkg::*;
#(
  parameter int IDX_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              any_hit,
  input  logic [IDX_W-1:0]  win_idx,
  input  logic [63:0]       win_addr,
  input  logic [KIND_W-1:0] win_kind,
  input  logic [15:0]       win_bdf,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_region,
  output logic [KIND_W-1:0] rsp_type,
  output logic [63:0]       rsp_addr,
  output logic [7:0]        rsp_bus,
  output logic [4:0]        rsp_dev,
  output logic [2:0]        rsp_func
);

  logic        cfg_hit;
  logic [15:0] bdf_d;

  assign cfg_hit = any_hit && is_cfg(win_kind);
  assign bdf_d   = cfg_hit ? win_bdf : 16'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_region <= '0;
      rsp_type   <= '0;
      rsp_addr   <= '0;
      rsp_bus    <= '0;
      rsp_dev    <= '0;
      rsp_func   <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid && any_hit;
      rsp_region <= req_valid ? win_idx  : '0;
      rsp_type   <= req_valid ? win_kind : '0;
      rsp_addr   <= req_valid ? win_addr : '0;
      rsp_bus    <= req_valid ? bdf_d[15:8]  : '0;
      rsp_dev    <= req_valid ? bdf_d[7:3]   : '0;
      rsp_func   <= req_valid ? bdf_d[2:0]   : '0;
    end
  end

endmodule

// File: rtl/outbound_atu.sv
module outbound_atu
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int ADDR_W      = 12,
  localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_region,
  output logic [4:0]        rsp_type,
  output logic [63:0]       rsp_addr,
  output logic [7:0]        rsp_bus,
  output logic [4:0]        rsp_dev,
  output logic [2:0]        rsp_func
);

  // Internal events brought out for the checker
  region_t [NUM_REGIONS-1:0] regs;
  logic [NUM_REGIONS-1:0]    hit_vec;
  logic [NUM_REGIONS-1:0]    en_vec;
  logic                      vp_inbound;
  logic                      win_access;
  logic                      any_hit;
  logic [IDX_W-1:0]          win_idx;
  logic [63:0]               win_addr;
  logic [KIND_W-1:0]         win_kind;
  logic [15:0]               win_bdf;

  generate
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_en
      assign en_vec[g] = regs[g].en;
    end
  endgenerate

  atu_regfile #(
    .NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .regs(regs),
    .vp_inbound(vp_inbound), .win_access(win_access)
  );

  atu_match #(
    .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)
  ) u_match (
    .regs(regs), .req_addr(req_addr), .hit_vec(hit_vec),
    .any_hit(any_hit), .win_idx(win_idx), .win_addr(win_addr),
    .win_kind(win_kind), .win_bdf(win_bdf)
  );

  atu_rsp_stage #(
    .IDX_W(IDX_W)
  ) u_rsp (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .any_hit(any_hit),
    .win_idx(win_idx), .win_addr(win_addr), .win_kind(win_kind),
    .win_bdf(win_bdf), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_region(rsp_region), .rsp_type(rsp_type), .rsp_addr(rsp_addr),
    .rsp_bus(rsp_bus), .rsp_dev(rsp_dev), .rsp_func(rsp_func)
  );

endmodule

// File: rtl/atu_checker.sv
module atu_checker
  import atu_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int IDX_W       = 1
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_we,
  input logic                      req_valid,
  input logic [63:0]               req_addr,
  input logic                      rsp_valid,
  input logic                      rsp_hit,
  input logic [IDX_W-1:0]          rsp_region,
  input logic [4:0]                rsp_type,
  input logic [63:0]               rsp_addr,
  input logic [7:0]                rsp_bus,
  input logic [4:0]                rsp_dev,
  input logic [2:0]                rsp_func,
  input region_t [NUM_REGIONS-1:0] regs,
  input logic [NUM_REGIONS-1:0]    hit_vec,
  input logic [NUM_REGIONS-1:0]    en_vec,
  input logic                      vp_inbound,
  input logic                      win_access
);

  p_rsp_follows_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit));

  p_low_index_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_vec[0]) |=> (rsp_hit && rsp_region == '0));

  p_miss_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_vec == '0) |=> (!rsp_hit && rsp_addr == $past(req_addr)));

  p_disabled_no_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && en_vec == '0) |=> !rsp_hit);

  p_bdf_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !(rsp_type == KIND_CFG0 || rsp_type == KIND_CFG1))
      |-> (rsp_bus == 8'h0 && rsp_dev == 5'h0 && rsp_func == 3'h0));

  p_inbound_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && vp_inbound && win_access) |=> $stable(regs));

endmodule

bind outbound_atu atu_checker #(
  .NUM_REGIONS(NUM_REGIONS), .IDX_W(IDX_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .req_valid(req_valid),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_region(rsp_region), .rsp_type(rsp_type), .rsp_addr(rsp_addr),
  .rsp_bus(rsp_bus), .rsp_dev(rsp_dev), .rsp_func(rsp_func),
  .regs(regs), .hit_vec(hit_vec), .en_vec(en_vec),
  .vp_inbound(vp_inbound), .win_access(win_access)
);

// File: tb/outbound_atu_tb_top.sv
module outbound_atu_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        req_valid = 1'b0;
  logic [63:0] req_addr = '0;
  logic        rsp_valid, rsp_hit;
  logic [0:0]  rsp_region;
  logic [4:0]  rsp_type;
  logic [63:0] rsp_addr;
  logic [7:0]  rsp_bus;
  logic [4:0]  rsp_dev;
  logic [2:0]  rsp_func;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  outbound_atu dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_region(rsp_region), .rsp_type(rsp_type), .rsp_addr(rsp_addr),
    .rsp_bus(rsp_bus), .rsp_dev(rsp_dev), .rsp_func(rsp_func)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #2;
    check(tag, {32'h0, reg_rdata}, {32'h0, exp});
  endtask

  // Request in one cycle, sample the response one clock later.
  task automatic req_chk(string tag, logic [63:0] a, logic hit,
                         logic [0:0] reg_i, logic [63:0] xa, logic [4:0] kind);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    check({tag, " valid"},  {63'h0, rsp_valid}, 64'h1);
    check({tag, " hit"},    {63'h0, rsp_hit}, {63'h0, hit});
    check({tag, " region"}, {63'h0, rsp_region}, {63'h0, reg_i});
    check({tag, " addr"},   rsp_addr, xa);
    check({tag, " type"},   {59'h0, rsp_type}, {59'h0, kind});
    req_valid = 1'b0;
  endtask

  task automatic bdf_chk(string tag, logic [63:0] a, logic [7:0] b,
                         logic [4:0] d, logic [2:0] f);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    check({tag, " bus"},  {56'h0, rsp_bus}, {56'h0, b});
    check({tag, " dev"},  {59'h0, rsp_dev}, {59'h0, d});
    check({tag, " func"}, {61'h0, rsp_func}, {61'h0, f});
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rsp_valid low", {63'h0, rsp_valid}, 64'h0);
    for (int k = 0; k < 8; k++)
      rd_chk("R1 reg zero", 12'h900 + 12'(4 * k), 32'h0);
    req_chk("R1 addr zero misses", 64'h0, 1'b0, 1'b0, 64'h0, 5'd0);
  endtask

  task automatic t_viewport;
    wr(12'h900, 32'h8000_0001);
    rd_chk("R2 selector readback", 12'h900, 32'h8000_0001);
    wr(12'h900, 32'h7FFF_FFF1);
    rd_chk("R2 selector masking", 12'h900, 32'h0000_0001);
    wr(12'h900, 32'h0);
  endtask

  task automatic t_program;
    // Region 0: memory, enable written first
    wr(12'h900, 32'h0);
    wr(12'h908, 32'hFFFF_FFFF);
    rd_chk("R4 ctrl2 masking", 12'h908, 32'hC000_0000);
    wr(12'h908, 32'h8000_0000);
    wr(12'h904, 32'hFFFF_FFE2);
    rd_chk("R4 ctrl1 masking", 12'h904, 32'h0000_0002);
    wr(12'h904, 32'h0);
    wr(12'h90C, 32'h1000_0000);
    wr(12'h910, 32'h0);
    wr(12'h914, 32'h1000_FFFF);
    wr(12'h918, 32'h0);
    wr(12'h91C, 32'h2);
    // Region 1: I/O
    wr(12'h900, 32'h1);
    wr(12'h904, 32'h2);
    wr(12'h90C, 32'h1000_8000);
    wr(12'h914, 32'h1001_7FFF);
    wr(12'h918, 32'h0000_4000);
    wr(12'h908, 32'h8000_0000);
    rd_chk("R3 region1 limit", 12'h914, 32'h1001_7FFF);
    wr(12'h900, 32'h0);
    rd_chk("R3 region0 base kept", 12'h90C, 32'h1000_0000);
    rd_chk("R3 region0 limit kept", 12'h914, 32'h1000_FFFF);
    rd_chk("R3 region0 utgt kept", 12'h91C, 32'h0000_0002);
  endtask

  task automatic t_translate;
    req_chk("R6 R7 low edge", 64'h1000_0000, 1'b1, 1'b0, 64'h2_0000_0000, 5'd0);
    req_chk("R6 R8 high edge overlap", 64'h1000_FFFF, 1'b1, 1'b0, 64'h2_0000_FFFF, 5'd0);
    req_chk("R7 region1 io", 64'h1001_0000, 1'b1, 1'b1, 64'h0000_C000, 5'd2);
    req_chk("R6 region1 high edge", 64'h1001_7FFF, 1'b1, 1'b1, 64'h0001_3FFF, 5'd2);
    req_chk("R9 above limit", 64'h1001_8000, 1'b0, 1'b0, 64'h1001_8000, 5'd0);
    req_chk("R9 below base", 64'h0FFF_FFFF, 1'b0, 1'b0, 64'h0FFF_FFFF, 5'd0);
    req_chk("R6 upper word mismatch", 64'h1_1000_0000, 1'b0, 1'b0, 64'h1_1000_0000, 5'd0);
    bdf_chk("R10 memory zero fields", 64'h1000_0010, 8'h0, 5'h0, 3'h0);
  endtask

  task automatic t_overlap;
    req_chk("R8 both hit region0", 64'h1000_8000, 1'b1, 1'b0, 64'h2_0000_8000, 5'd0);
    wr(12'h900, 32'h0);
    wr(12'h908, 32'h0);
    req_chk("R6 disabled region skipped", 64'h1000_8000, 1'b1, 1'b1, 64'h0000_4000, 5'd2);
  endtask

  task automatic t_cfg;
    wr(12'h900, 32'h1);
    wr(12'h904, 32'h4);
    wr(12'h918, 32'h12FD_0000);  // bus 0x12, dev 0x1F, func 5
    req_chk("R10 cfg0 addr", 64'h1000_8004, 1'b1, 1'b1, 64'h12FD_0004, 5'd4);
    bdf_chk("R10 cfg0 fields", 64'h1000_8004, 8'h12, 5'h1F, 3'h5);
    wr(12'h904, 32'h5);
    bdf_chk("R10 cfg1 fields", 64'h1000_8040, 8'h12, 5'h1F, 3'h5);
  endtask

  task automatic t_inbound;
    wr(12'h900, 32'h8000_0000);
    wr(12'h90C, 32'hDEAD_BEEF);
    rd_chk("R5 inbound window reads zero", 12'h90C, 32'h0);
    wr(12'h900, 32'h0);
    rd_chk("R5 inbound write dropped", 12'h90C, 32'h1000_0000);
    wr(12'h90D, 32'h5555_5555);
    rd_chk("R5 misaligned reads zero", 12'h90D, 32'h0);
    rd_chk("R5 misaligned write dropped", 12'h90C, 32'h1000_0000);
  endtask

  task automatic t_reprogram;
    wr(12'h900, 32'h1);
    wr(12'h90C, 32'h3000_0000);
    wr(12'h914, 32'h3000_00FF);
    req_chk("R12 moved window", 64'h3000_0010, 1'b1, 1'b1, 64'h12FD_0010, 5'd5);
    req_chk("R12 old window gone", 64'h1000_8004, 1'b0, 1'b0, 64'h1000_8004, 5'd0);
    req_chk("R12 moved limit", 64'h3000_0100, 1'b0, 1'b0, 64'h3000_0100, 5'd0);
  endtask

  task automatic t_stream;
    @(negedge clk);
    req_valid = 1'b1; req_addr = 64'h3000_0001;
    @(negedge clk);
    check("R11 first of pair valid", {63'h0, rsp_valid}, 64'h1);
    check("R11 first of pair addr", rsp_addr, 64'h12FD_0001);
    req_addr = 64'h3000_0002;
    @(negedge clk);
    check("R11 second of pair addr", rsp_addr, 64'h12FD_0002);
    req_valid = 1'b0;
    @(negedge clk);
    check("R11 idle after pair", {63'h0, rsp_valid}, 64'h0);
    check("R11 no hit when idle", {63'h0, rsp_hit}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_viewport;
    t_program;
    t_translate;
    t_overlap;
    t_cfg;
    t_inbound;
    t_reprogram;
    t_stream;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule